// File: doc/BRIEF.md
# Exponential L1 Timeout Timer

This block measures how long a USB2 port has stayed in the L1 low-power link state. Each port has a 4-bit timeout code set by the driver. A 4-bit global override code can replace it. The block picks the effective code when a start pulse arrives and converts that code into a number of microseconds. The duration doubles with each code step, from 8 µs at code 1 up to 131072 µs at code 15. The block then counts 1 µs tick pulses until that number is reached.

The protocol controller around the block gives a start pulse when the link enters L1. It gives a cancel when the link leaves L1 early. It watches for the one-cycle expiry pulse. The busy flag shows that a count is in progress. All pins are plain control and status levels or pulses. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `l1_timeout_timer`

## Requirements
- R1: After reset, `busy_o` and `expire_o` are both 0.
- R2: When `ovrd_code_i` is non-zero at the start pulse, it is the effective code and `port_code_i` is ignored.
- R3: When `ovrd_code_i` is zero at the start pulse, `port_code_i` is the effective code.
- R4: A non-zero effective code N gives a duration of 8 × 2^(N-1) ticks. Code 1 is 8 ticks, code 2 is 16, code 3 is 32 and code 15 is 131072. Expiry follows exactly that many counted ticks.
- R5: A start pulse whose effective code is 0 leaves the timer idle. Any running count is abandoned. No expiry follows, however many ticks arrive.
- R6: The effective duration is captured at the start pulse. Changes to either code while a count runs do not change when the count expires.
- R7: `expire_o` is high for exactly one cycle. `busy_o` is already low in that same cycle.
- R8: `cancel_i` sets `busy_o` low on the next cycle and no expiry occurs. Cancel has priority over start and over a tick in the same cycle.
- R9: A tick counts only while `busy_o` is high and no start pulse is present in the same cycle. Cycles without a tick do not advance the count.
- R10: A start pulse while busy restarts the count from zero with the newly selected duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins (or restarts) a timeout |
| cancel_i | input | 1 | Stops a running timeout without an expiry |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| port_code_i | input | 4 | Per-port timeout code from the driver |
| ovrd_code_i | input | 4 | Global override code, 0 = use the per-port code |
| expire_o | output | 1 | One-cycle pulse when the timeout elapses |
| busy_o | output | 1 | A timeout count is in progress |

## Verification
`busy_o` reflects a start or cancel sampled at a clock edge from that edge on. `expire_o` rises at the edge that samples the final counted tick, and `busy_o` falls at that same edge. The bench drives every input at the falling edge and reads outputs at the next falling edge, so each check looks at the first cycle in which a result is due. Every tick before the last one is also checked for a premature expiry. The cycle after an expiry is checked to confirm the pulse has ended.

// File: rtl/l1tmr_pkg.sv
package l1tmr_pkg;
  localparam int unsigned DEF_CODE_W     = 4;
  localparam int unsigned DEF_BASE_TICKS = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tmr_state_e;

  function automatic int unsigned max_ticks(input int unsigned code_w,
                                            input int unsigned base);
    return base << ((1 << code_w) - 2);
  endfunction
endpackage

// File: rtl/l1tmr_code_sel.sv
module l1tmr_code_sel #(
  parameter int unsigned CODE_W = l1tmr_pkg::DEF_CODE_W
) (
  input  logic [CODE_W-1:0] port_code_i,
  input  logic [CODE_W-1:0] ovrd_code_i,
  output logic [CODE_W-1:0] eff_code_o,
  output logic              eff_zero_o
);
  logic use_ovrd;

  always_comb begin
    use_ovrd   = (ovrd_code_i != '0);
    eff_code_o = use_ovrd ? ovrd_code_i : port_code_i;
    eff_zero_o = (eff_code_o == '0);
  end

  always_comb begin
    if (!$isunknown(ovrd_code_i) && !$isunknown(port_code_i)) begin
      // R2
      ovrd_wins_chk: assert (ovrd_code_i == '0 || eff_code_o == ovrd_code_i);
      // R3
      port_fallback_chk: assert (ovrd_code_i != '0 || eff_code_o == port_code_i);
    end
  end
endmodule

// File: rtl/l1tmr_dur_conv.sv
module l1tmr_dur_conv #(
  parameter int unsigned CODE_W     = l1tmr_pkg::DEF_CODE_W,
  parameter int unsigned BASE_TICKS = l1tmr_pkg::DEF_BASE_TICKS,
  parameter int unsigned CNT_W      = 18
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  dur_o
);
  localparam int unsigned NCODES = 1 << CODE_W;

  logic [CNT_W-1:0] term [NCODES];

  assign term[0] = '0;

  for (genvar gi = 1; gi < NCODES; gi++) begin : g_term
    localparam logic [CNT_W-1:0] TICKS = CNT_W'(BASE_TICKS) << (gi - 1);
    assign term[gi] = (code_i == CODE_W'(gi)) ? TICKS : '0;
  end

  always_comb begin
    dur_o = '0;
    for (int k = 0; k < NCODES; k++) dur_o = dur_o | term[k];
  end

  always_comb begin
    if (!$isunknown(code_i)) begin
      // R4
      dur_pow2_chk: assert ((code_i == '0) ? (dur_o == '0) : ($countones(dur_o) == 1));
    end
  end
endmodule

// File: rtl/l1tmr_tick_cnt.sv
module l1tmr_tick_cnt #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             busy_o,
  output logic             expire_o
);
  import l1tmr_pkg::*;

  tmr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             exp_q;
  logic             last_tick;

  assign last_tick = (cnt_q + CNT_W'(1)) == lim_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
      exp_q   <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (clear_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (load_i) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
        lim_q   <= lim_i;
      end else if (state_q == ST_RUN && tick_i) begin
        if (last_tick) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
          exp_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign expire_o = exp_q;

  // R7
  exp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  // R7
  exp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !busy_o);
  // R8
  cancel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!busy_o && !expire_o));
  // R9
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !clear_i && !load_i) |=> (busy_o && $stable(cnt_q)));
  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q < lim_q));
  // R10
  load_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> (busy_o && cnt_q == '0));
endmodule

// File: rtl/l1_timeout_timer.sv
module l1_timeout_timer #(
  parameter int unsigned CODE_W     = l1tmr_pkg::DEF_CODE_W,
  parameter int unsigned BASE_TICKS = l1tmr_pkg::DEF_BASE_TICKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cancel_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] port_code_i,
  input  logic [CODE_W-1:0] ovrd_code_i,
  output logic              expire_o,
  output logic              busy_o
);
  localparam int unsigned MAX_T = l1tmr_pkg::max_ticks(CODE_W, BASE_TICKS);
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic [CODE_W-1:0] eff_code;
  logic              eff_zero;
  logic [CNT_W-1:0]  dur;
  logic              load;
  logic              clear;

  l1tmr_code_sel #(.CODE_W(CODE_W)) u_sel (
    .port_code_i (port_code_i),
    .ovrd_code_i (ovrd_code_i),
    .eff_code_o  (eff_code),
    .eff_zero_o  (eff_zero)
  );

  l1tmr_dur_conv #(
    .CODE_W     (CODE_W),
    .BASE_TICKS (BASE_TICKS),
    .CNT_W      (CNT_W)
  ) u_conv (
    .code_i (eff_code),
    .dur_o  (dur)
  );

  assign clear = cancel_i | (start_i & eff_zero);
  assign load  = start_i & ~cancel_i & ~eff_zero;

  l1tmr_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .clear_i  (clear),
    .tick_i   (tick_i),
    .lim_i    (dur),
    .busy_o   (busy_o),
    .expire_o (expire_o)
  );

  // R5
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ovrd_code_i == '0 && port_code_i == '0) |=> (!busy_o && !expire_o));
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (!busy_o && !expire_o));
endmodule

// File: tb/l1_timeout_timer_tb.sv
module l1_timeout_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cancel = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] port = 4'h0;
  logic [3:0] ovrd = 4'h0;
  logic       expire;
  logic       busy;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  l1_timeout_timer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .cancel_i    (cancel),
    .tick_i      (tick),
    .port_code_i (port),
    .ovrd_code_i (ovrd),
    .expire_o    (expire),
    .busy_o      (busy)
  );

  // {override code, port code, expected ticks; 0 = never expires}
  localparam logic [27:0] VEC [8] = '{
    {4'h0, 4'h1, 20'd8},
    {4'h0, 4'h3, 20'd32},
    {4'h2, 4'h5, 20'd16},
    {4'h4, 4'h0, 20'd64},
    {4'h0, 4'h0, 20'd0},
    {4'h1, 4'hF, 20'd8},
    {4'h0, 4'h7, 20'd512},
    {4'h6, 4'h6, 20'd256}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ends at a falling edge with the start sampled
  task automatic do_start(input logic [3:0] ov, input logic [3:0] pc);
    ovrd  = ov;
    port  = pc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // n ticks back to back; returns the count of cycles that looked wrong before the last
  task automatic ticks(input int n, output int early);
    early = 0;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (i < n - 1 && (expire || !busy)) early++;
    end
    tick = 1'b0;
  endtask

  task automatic expect_expiry(input string req, input int n);
    int early;
    ticks(n, early);
    chk({req, " no early expiry"}, early, 0);
    chk({req, " expire/busy at limit"}, {30'd0, expire, busy}, 2);
    @(negedge clk);
    chk({req, " pulse one cycle"}, {31'd0, expire}, 0);
  endtask

  task automatic expect_silent(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (expire || busy) seen++;
    end
    tick = 1'b0;
    chk({req, " stays idle"}, seen, 0);
  endtask

  initial begin
    int early;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 expire", {31'd0, expire}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: table walk
    for (int v = 0; v < 8; v++) begin
      do_start(VEC[v][27:24], VEC[v][23:20]);
      if (VEC[v][19:0] == 20'd0) begin
        expect_silent("R5 disabled code", 600);
      end else begin
        chk("R2/R3 busy after start", {31'd0, busy}, 1);
        expect_expiry(VEC[v][27:24] != 4'h0 ? "R2 override" : "R3 port code",
                      int'(VEC[v][19:0]));
      end
    end

    // R6: codes changed mid-count
    do_start(4'h0, 4'h2);
    ticks(5, early);
    port = 4'h1;
    ovrd = 4'h3;
    expect_expiry("R6 latched", 11);

    // R8: cancel mid-count, then ticks give nothing
    do_start(4'h0, 4'h1);
    ticks(3, early);
    cancel = 1'b1;
    @(negedge clk);
    cancel = 1'b0;
    chk("R8 busy after cancel", {30'd0, expire, busy}, 0);
    expect_silent("R8 after cancel", 40);

    // R8: cancel coinciding with the final tick
    do_start(4'h0, 4'h1);
    ticks(7, early);
    tick   = 1'b1;
    cancel = 1'b1;
    @(negedge clk);
    tick   = 1'b0;
    cancel = 1'b0;
    chk("R8 cancel beats last tick", {30'd0, expire, busy}, 0);
    @(negedge clk);
    chk("R8 no late pulse", {31'd0, expire}, 0);

    // R8: cancel and start together
    cancel = 1'b1;
    do_start(4'h1, 4'h1);
    cancel = 1'b0;
    chk("R8 cancel beats start", {31'd0, busy}, 0);

    // R9: tick in the start cycle is not counted
    tick = 1'b1;
    do_start(4'h1, 4'h0);
    tick = 1'b0;
    expect_expiry("R9 start-cycle tick", 8);

    // R9: gaps between ticks do not advance the count
    do_start(4'h1, 4'h0);
    for (int i = 0; i < 7; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (3) @(negedge clk);
    end
    chk("R9 gaps busy", {30'd0, expire, busy}, 1);
    expect_expiry("R9 gapped last", 1);

    // R10: restart while busy
    do_start(4'h2, 4'h0);
    ticks(10, early);
    do_start(4'h1, 4'h0);
    expect_expiry("R10 restart", 8);

    // R5: start with zero code abandons a running count
    do_start(4'h0, 4'h4);
    ticks(6, early);
    do_start(4'h0, 4'h0);
    expect_silent("R5 abandon", 100);

    // R4: largest code
    do_start(4'hF, 4'h0);
    expect_expiry("R4 code 15", 131072);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule